// File: doc/BRIEF.md
# Instruction Namespace Control Registers

This block holds the hidden opcode bits that extend every fetched instruction before it reaches the decoder. Each privilege level has its own set of three 32-bit registers. The live namespace register selects how instructions are interpreted. The saved register keeps the namespace that was interrupted by a trap. The handler register gives the namespace that trap handlers run in. The live register of the privilege level named on `cur_priv` is decoded into plain selector signals: native versus foreign mode, the 16-bit opcode page, the instruction byte order, and the foreign-architecture index.

Software reaches the registers through a simple control port. Any write asking for a value the hardware cannot hold is refused outright. The block never coerces such a value to a nearby legal one. Instead it raises a one-cycle illegal pulse with the faulting address, so the pipeline can take an illegal-instruction trap and software can fall back to emulation. On trap entry and trap return the target level's registers are exchanged in a single clock edge. A release pulse in the following cycle tells the PC logic that the new namespace is in place and the PC may now move.

The control port has no back-pressure: a request is taken in the cycle `csr_valid` is high. Reads are combinational. Trap requests are single-cycle strobes and are always accepted.

Top module: `ns_csr_unit`

## Requirements
- R1: After reset, every live, saved and handler register of every level reads zero, so the decoded outputs show native mode, page 0 and little-endian.
- R2: Bit 0 of the live value selects foreign mode. In native mode `dec_page` is bits 5..1, `dec_big_endian` is bit 6 and `dec_foreign_idx` is 0. In foreign mode `dec_foreign_idx` is bits 7..1, and both `dec_page` and `dec_big_endian` are 0.
- R3: A native-mode value (bit 0 = 0) is legal only if bits 31..7 are zero and its page is one of the supported pages. By default the supported pages are 0, 1 and 8. Big-endian (bit 6) is allowed in the default configuration.
- R4: A foreign-mode value (bit 0 = 1) is legal only if bits 31..8 are zero and its 7-bit index is supported. By default the supported indices are 16 (official) and 64 (custom).
- R5: A write that is illegal leaves all registers unchanged. In the next cycle `csr_illegal` is high for one cycle and `csr_illegal_addr` holds the written address. The same legality rule applies to all three register kinds. A write to kind 3 is always illegal.
- R6: `csr_addr` is {level, kind}, with kind in bits 1..0: 0 = live, 1 = saved, 2 = handler, 3 = none. `csr_rdata` returns the addressed register in the same cycle, and returns 0 for kind 3.
- R7: On `trap_enter`, the level `trap_priv` copies live into saved and loads live from handler. Other levels are unchanged. `pc_release` is high in the next cycle.
- R8: On `trap_return`, the level `trap_priv` copies saved into live and then reloads saved from handler. `pc_release` is high in the next cycle.
- R9: When a trap strobe and a control write arrive in the same cycle, the write is discarded and raises no illegal pulse. When entry and return arrive together, only the entry takes effect.
- R10: The decoded outputs follow the live register of the level on `cur_priv`, and change in the same cycle as `cur_priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Control request this cycle |
| csr_write | input | 1 | Request is a write |
| csr_addr | input | PRIV_W+2 | {level, kind} address |
| csr_wdata | input | 32 | Write value |
| csr_rdata | output | 32 | Addressed register value |
| csr_illegal | output | 1 | Refused-write pulse |
| csr_illegal_addr | output | PRIV_W+2 | Address of the refused write |
| trap_enter | input | 1 | Trap entry strobe |
| trap_return | input | 1 | Trap return strobe |
| trap_priv | input | PRIV_W | Level the trap targets |
| pc_release | output | 1 | Namespace swap done, PC may move |
| cur_priv | input | PRIV_W | Level whose namespace is decoded |
| dec_foreign | output | 1 | Foreign-mode select |
| dec_page | output | 5 | 16-bit opcode page |
| dec_big_endian | output | 1 | Big-endian instruction meaning |
| dec_foreign_idx | output | 7 | Foreign-architecture index |

## Verification
Several properties are checked on every cycle. An illegal pulse must follow a control write made in a cycle without a trap, and it must carry that write's address. A refused write must leave the decoded outputs unchanged. Every trap strobe must be followed by `pc_release`, and every `pc_release` must be preceded by a strobe. Foreign and native decoded fields must never both be non-zero. Other behaviour can only be shown by the bench's scenarios, which compare the block against a behavioural model on every clock: which exact values are legal, the copy order of the register swap on entry and return, that other levels stay untouched, and that a write coinciding with a trap is dropped.

// File: rtl/ns_csr_pkg.sv
package ns_csr_pkg;
  localparam int NS_W      = 32;
  localparam int PAGE_LSB  = 1;
  localparam int PAGE_W    = 5;
  localparam int ENDIAN_B  = 6;
  localparam int FIDX_LSB  = 1;
  localparam int FIDX_W    = 7;
  localparam int RV_TOP    = ENDIAN_B + 1;      // first bit that must be zero in native mode
  localparam int FR_TOP    = FIDX_LSB + FIDX_W; // first bit that must be zero in foreign mode

  typedef enum logic [1:0] {
    KIND_LIVE    = 2'd0,
    KIND_SAVED   = 2'd1,
    KIND_HANDLER = 2'd2,
    KIND_NONE    = 2'd3
  } ns_kind_e;

  typedef struct packed {
    logic              foreign;
    logic [PAGE_W-1:0] page;
    logic              big_endian;
    logic [FIDX_W-1:0] fidx;
  } ns_dec_t;
endpackage

// File: rtl/ns_legal_chk.sv
module ns_legal_chk
  import ns_csr_pkg::*;
#(
  parameter logic [2**PAGE_W-1:0] RV_PAGES    = 32'h0000_0103,
  parameter bit                   BE_OK       = 1'b1,
  parameter logic [2**FIDX_W-1:0] FOREIGN_IDS = (128'd1 << 16) | (128'd1 << 64)
) (
  input  logic [NS_W-1:0] value,
  output logic            legal
);
  logic [PAGE_W-1:0] page;
  logic [FIDX_W-1:0] fidx;
  logic              rv_ok;
  logic              fr_ok;

  assign page  = value[PAGE_LSB +: PAGE_W];
  assign fidx  = value[FIDX_LSB +: FIDX_W];
  assign rv_ok = (value[NS_W-1:RV_TOP] == '0) && RV_PAGES[page] && (BE_OK || !value[ENDIAN_B]);
  assign fr_ok = (value[NS_W-1:FR_TOP] == '0) && FOREIGN_IDS[fidx];
  assign legal = value[0] ? fr_ok : rv_ok;
endmodule

// File: rtl/ns_bank.sv
module ns_bank
  import ns_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            enter,
  input  logic            leave,
  input  logic            wr_en,
  input  ns_kind_e        wr_kind,
  input  logic [NS_W-1:0] wr_data,
  output logic [NS_W-1:0] live_q,
  output logic [NS_W-1:0] saved_q,
  output logic [NS_W-1:0] handler_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= '0;
      saved_q   <= '0;
      handler_q <= '0;
    end else if (enter) begin
      saved_q <= live_q;
      live_q  <= handler_q;
    end else if (leave) begin
      live_q  <= saved_q;
      saved_q <= handler_q;
    end else if (wr_en) begin
      case (wr_kind)
        KIND_LIVE:    live_q    <= wr_data;
        KIND_SAVED:   saved_q   <= wr_data;
        KIND_HANDLER: handler_q <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ns_decode.sv
module ns_decode
  import ns_csr_pkg::*;
(
  input  logic [NS_W-1:0] value,
  output ns_dec_t         dec
);
  always_comb begin
    dec = '0;
    dec.foreign = value[0];
    if (value[0]) begin
      dec.fidx = value[FIDX_LSB +: FIDX_W];
    end else begin
      dec.page       = value[PAGE_LSB +: PAGE_W];
      dec.big_endian = value[ENDIAN_B];
    end
  end
endmodule

// File: rtl/ns_csr_unit.sv
module ns_csr_unit
  import ns_csr_pkg::*;
#(
  parameter int                   NUM_PRIV    = 4,
  parameter int                   PRIV_W      = (NUM_PRIV > 1) ? $clog2(NUM_PRIV) : 1,
  parameter logic [2**PAGE_W-1:0] RV_PAGES    = 32'h0000_0103,
  parameter bit                   BE_OK       = 1'b1,
  parameter logic [2**FIDX_W-1:0] FOREIGN_IDS = (128'd1 << 16) | (128'd1 << 64),
  localparam int                  ADDR_W      = PRIV_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_valid,
  input  logic              csr_write,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [NS_W-1:0]   csr_wdata,
  output logic [NS_W-1:0]   csr_rdata,
  output logic              csr_illegal,
  output logic [ADDR_W-1:0] csr_illegal_addr,
  input  logic              trap_enter,
  input  logic              trap_return,
  input  logic [PRIV_W-1:0] trap_priv,
  output logic              pc_release,
  input  logic [PRIV_W-1:0] cur_priv,
  output logic              dec_foreign,
  output logic [PAGE_W-1:0] dec_page,
  output logic              dec_big_endian,
  output logic [FIDX_W-1:0] dec_foreign_idx
);
  logic [NS_W-1:0]   live_q    [NUM_PRIV];
  logic [NS_W-1:0]   saved_q   [NUM_PRIV];
  logic [NS_W-1:0]   handler_q [NUM_PRIV];
  logic [PRIV_W-1:0] addr_priv;
  ns_kind_e          addr_kind;
  logic              addr_ok;
  logic              value_ok;
  logic              any_trap;
  logic              wr_fire;
  logic              wr_ok;
  logic              wr_bad;
  logic [NS_W-1:0]   cur_live;
  ns_dec_t           dec;

  assign addr_priv = csr_addr[ADDR_W-1:2];
  assign addr_kind = ns_kind_e'(csr_addr[1:0]);
  assign addr_ok   = (int'(addr_priv) < NUM_PRIV) && (addr_kind != KIND_NONE);
  assign any_trap  = trap_enter | trap_return;
  assign wr_fire   = csr_valid & csr_write & ~any_trap;
  assign wr_ok     = wr_fire & addr_ok & value_ok;
  assign wr_bad    = wr_fire & ~(addr_ok & value_ok);

  ns_legal_chk #(
    .RV_PAGES(RV_PAGES), .BE_OK(BE_OK), .FOREIGN_IDS(FOREIGN_IDS)
  ) u_legal (
    .value(csr_wdata),
    .legal(value_ok)
  );

  for (genvar g = 0; g < NUM_PRIV; g++) begin : g_lvl
    logic lvl_hit;
    assign lvl_hit = (trap_priv == PRIV_W'(g));
    ns_bank u_bank (
      .clk      (clk),
      .rst      (rst),
      .enter    (trap_enter & lvl_hit),
      .leave    (trap_return & ~trap_enter & lvl_hit),
      .wr_en    (wr_ok & (addr_priv == PRIV_W'(g))),
      .wr_kind  (addr_kind),
      .wr_data  (csr_wdata),
      .live_q   (live_q[g]),
      .saved_q  (saved_q[g]),
      .handler_q(handler_q[g])
    );
  end

  always_comb begin
    csr_rdata = '0;
    if (int'(addr_priv) < NUM_PRIV) begin
      case (addr_kind)
        KIND_LIVE:    csr_rdata = live_q[addr_priv];
        KIND_SAVED:   csr_rdata = saved_q[addr_priv];
        KIND_HANDLER: csr_rdata = handler_q[addr_priv];
        default:      csr_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_illegal      <= 1'b0;
      csr_illegal_addr <= '0;
      pc_release       <= 1'b0;
    end else begin
      csr_illegal <= wr_bad;
      pc_release  <= any_trap;
      if (wr_bad) csr_illegal_addr <= csr_addr;
    end
  end

  assign cur_live = (int'(cur_priv) < NUM_PRIV) ? live_q[cur_priv] : '0;

  ns_decode u_dec (
    .value(cur_live),
    .dec  (dec)
  );

  assign dec_foreign     = dec.foreign;
  assign dec_page        = dec.page;
  assign dec_big_endian  = dec.big_endian;
  assign dec_foreign_idx = dec.fidx;
endmodule

// File: rtl/ns_csr_unit_chk.sv
module ns_csr_unit_chk #(
  parameter int  PRIV_W = 2,
  localparam int ADDR_W = PRIV_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_valid,
  input logic              csr_write,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              csr_illegal,
  input logic [ADDR_W-1:0] csr_illegal_addr,
  input logic              trap_enter,
  input logic              trap_return,
  input logic              pc_release,
  input logic [PRIV_W-1:0] cur_priv,
  input logic              dec_foreign,
  input logic [4:0]        dec_page,
  input logic              dec_big_endian,
  input logic [6:0]        dec_foreign_idx
);
  p_illegal_src_r5: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> $past(csr_valid && csr_write && !trap_enter && !trap_return));

  p_illegal_addr_r5: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> (csr_illegal_addr == $past(csr_addr)));

  p_illegal_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (csr_illegal && $stable(cur_priv)) |->
      $stable({dec_foreign, dec_page, dec_big_endian, dec_foreign_idx}));

  p_trap_drops_write_r9: assert property (@(posedge clk) disable iff (rst)
    (trap_enter || trap_return) |=> !csr_illegal);

  p_release_cause_r7: assert property (@(posedge clk) disable iff (rst)
    pc_release |-> $past(trap_enter || trap_return));

  p_release_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (trap_enter || trap_return) |=> pc_release);

  p_foreign_fields_r2: assert property (@(posedge clk) disable iff (rst)
    dec_foreign |-> (dec_page == 5'd0 && !dec_big_endian));

  p_native_fields_r2: assert property (@(posedge clk) disable iff (rst)
    !dec_foreign |-> (dec_foreign_idx == 7'd0));
endmodule

bind ns_csr_unit ns_csr_unit_chk #(.PRIV_W(PRIV_W)) u_chk (
  .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_write(csr_write),
  .csr_addr(csr_addr), .csr_illegal(csr_illegal), .csr_illegal_addr(csr_illegal_addr),
  .trap_enter(trap_enter), .trap_return(trap_return), .pc_release(pc_release),
  .cur_priv(cur_priv), .dec_foreign(dec_foreign), .dec_page(dec_page),
  .dec_big_endian(dec_big_endian), .dec_foreign_idx(dec_foreign_idx)
);

// File: tb/test_ns_csr_unit.sv
module test_ns_csr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_valid = 1'b0, csr_write = 1'b0;
  logic [3:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic [3:0]  csr_illegal_addr;
  logic        trap_enter = 1'b0, trap_return = 1'b0;
  logic [1:0]  trap_priv = '0, cur_priv = '0;
  logic        pc_release, dec_foreign, dec_big_endian;
  logic [4:0]  dec_page;
  logic [6:0]  dec_foreign_idx;

  int checks = 0, failures = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ns_csr_unit i_ns_csr_unit (.*);

  // behavioural reference
  logic [31:0] m_live [4], m_saved [4], m_hand [4];
  bit          m_ready = 0, e_ill = 0, e_rel = 0;
  logic [3:0]  e_ill_addr = '0;

  function automatic bit ok_value(logic [31:0] v);
    int unsigned x = v;
    if (x % 2 == 1) begin
      int unsigned id = (x / 2) % 128;
      return (x < 256) && (id == 16 || id == 64);
    end else begin
      int unsigned pg = (x / 2) % 32;
      return (x < 128) && (pg == 0 || pg == 1 || pg == 8);
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_live[i] = 0; m_saved[i] = 0; m_hand[i] = 0; end
      e_ill = 0; e_rel = 0; m_ready = 1;
    end else begin
      e_rel = trap_enter || trap_return;
      e_ill = 0;
      if (trap_enter) begin
        m_saved[trap_priv] = m_live[trap_priv];
        m_live[trap_priv]  = m_hand[trap_priv];
      end else if (trap_return) begin
        m_live[trap_priv]  = m_saved[trap_priv];
        m_saved[trap_priv] = m_hand[trap_priv];
      end else if (csr_valid && csr_write) begin
        if (csr_addr[1:0] != 2'd3 && ok_value(csr_wdata)) begin
          case (csr_addr[1:0])
            2'd0: m_live[csr_addr[3:2]]  = csr_wdata;
            2'd1: m_saved[csr_addr[3:2]] = csr_wdata;
            default: m_hand[csr_addr[3:2]] = csr_wdata;
          endcase
        end else begin
          e_ill = 1; e_ill_addr = csr_addr;
        end
      end
    end
  end

  task automatic cmp(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s [%s] got=%h exp=%h at %0t", req, tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_ready) begin
      logic [31:0] v, r;
      v = m_live[cur_priv];
      case (csr_addr[1:0])
        2'd0: r = m_live[csr_addr[3:2]];
        2'd1: r = m_saved[csr_addr[3:2]];
        2'd2: r = m_hand[csr_addr[3:2]];
        default: r = 0;
      endcase
      cmp("R6 rdata", csr_rdata, r);
      cmp("R2 R10 foreign", {31'd0, dec_foreign}, {31'd0, v[0]});
      cmp("R2 R10 page", {27'd0, dec_page}, v[0] ? 32'd0 : (v >> 1) & 32'h1f);
      cmp("R2 R10 endian", {31'd0, dec_big_endian}, v[0] ? 32'd0 : (v >> 6) & 32'h1);
      cmp("R2 R10 index", {25'd0, dec_foreign_idx}, v[0] ? (v >> 1) & 32'h7f : 32'd0);
      cmp("R5 R9 illegal", {31'd0, csr_illegal}, {31'd0, e_ill});
      if (e_ill) cmp("R5 illegal_addr", {28'd0, csr_illegal_addr}, {28'd0, e_ill_addr});
      cmp("R7 R8 release", {31'd0, pc_release}, {31'd0, e_rel});
    end
  end

  task automatic op(input bit v, input bit w, input logic [3:0] a, input logic [31:0] d,
                    input bit te, input bit tr, input logic [1:0] tp, input logic [1:0] cp);
    @(posedge clk); #1;
    csr_valid = v; csr_write = w; csr_addr = a; csr_wdata = d;
    trap_enter = te; trap_return = tr; trap_priv = tp; cur_priv = cp;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] cp);
    op(1, 1, a, d, 0, 0, 0, cp);
    op(0, 0, a, 0, 0, 0, 0, cp);  // hold address to read back the result
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: all registers zero after reset
    tag = "R1";
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 3; k++) op(0, 0, 4'(l * 4 + k), 0, 0, 0, 0, 2'(l));
    // R3: native values on level 0
    tag = "R3";
    wr(4'h0, 32'h0000_0002, 0);   // page 1
    wr(4'h0, 32'h0000_0050, 0);   // page 8, big-endian
    wr(4'h0, 32'h0000_0004, 0);   // page 2 unsupported
    wr(4'h0, 32'h0010_0000, 0);   // reserved bit
    wr(4'h0, 32'h0100_0000, 0);   // custom bit
    wr(4'h0, 32'h0000_0080, 0);   // bit 7 set
    // R4: foreign values on level 1
    tag = "R4";
    wr(4'h4, 32'h0000_0021, 1);   // index 16
    wr(4'h4, 32'h0000_0081, 1);   // index 64
    wr(4'h4, 32'h0000_000B, 1);   // index 5 unsupported
    wr(4'h4, 32'h0000_0221, 1);   // bit 9 set
    // R5: saved/handler kinds and the empty kind
    tag = "R5";
    wr(4'hE, 32'h0000_0021, 3);   // handler L3 = foreign 16
    wr(4'hD, 32'h0000_0012, 3);   // saved L3 = page 9 unsupported
    wr(4'hD, 32'h0000_0010, 3);   // saved L3 = page 8
    wr(4'hF, 32'h0000_0002, 3);   // kind 3
    wr(4'hC, 32'h0000_0042, 3);   // live L3 = page 1 BE
    // R7: entry on level 3
    tag = "R7";
    op(0, 0, 4'hD, 0, 1, 0, 3, 3);
    op(0, 0, 4'hC, 0, 0, 0, 3, 3);
    op(0, 0, 4'h0, 0, 0, 0, 3, 0);   // level 0 untouched
    // R8: return on level 3
    tag = "R8";
    op(0, 0, 4'hC, 0, 0, 1, 3, 3);
    op(0, 0, 4'hD, 0, 0, 0, 3, 3);
    // R9: trap with simultaneous write, entry with return
    tag = "R9";
    op(1, 1, 4'h8, 32'h0000_0002, 1, 0, 2, 2);
    op(1, 1, 4'h8, 32'h0000_0004, 0, 1, 2, 2);
    op(0, 0, 4'h8, 0, 1, 1, 3, 3);
    op(0, 0, 4'hD, 0, 0, 0, 3, 3);
    // R10: switch decoded level
    tag = "R10";
    for (int l = 0; l < 4; l++) op(0, 0, 4'(l * 4), 0, 0, 0, 0, 2'(l));
    // mixed traffic
    tag = "R3 R4 R5 R7 R8 R9";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] pool [10];
      int r;
      pool = '{32'h2, 32'h50, 32'h21, 32'h81, 32'h10, 32'h4, 32'hB, 32'h0010_0000, 32'h40, 32'h1};
      r = $urandom % 100;
      op($urandom % 2 == 0, $urandom % 3 != 0, 4'($urandom), pool[$urandom % 10],
         r < 10, r >= 8 && r < 18, 2'($urandom), 2'($urandom));
    end
    op(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule